// File: doc/BRIEF.md
# Effective Address Generator

This block forms the address for the memory and control instructions of a 16-bit, word-addressed processor. Each instruction arrives with its instruction word, the program counter that has already been advanced past it, and the value of the base register that bits [8:6] select. The register file reads that value; this block does not. The block decodes the opcode in bits [15:12] and sign-extends the offset field that the opcode uses. It adds the offset to either the PC or the base value, and all address sums wrap modulo 2^16.

One cycle after `start`, the block presents its result as registered outputs.
- A direct load or store gives a memory access strobe, with the direction taken from opcode bit 0.
- The address-only form gives a register write value.
- A register jump gives a jump target.
- The two indirect opcodes run in two phases. In the first phase the block holds a pointer-read request on the PC-relative address and stays busy. When the memory returns the pointer word with `ptr_valid`, the next cycle issues the real access to that word.

Top module: `ea_gen`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `mem_go`, `ptr_rd`, `reg_wr_en`, `jmp_go`, `done` and `busy` are all 0.
- R2: For opcode 0010 (load) or 0011 (store), `addr` is `pc_inc + sext(instr[8:0])` one cycle after `start`. In that cycle `mem_go`=1 and `done`=1, and `mem_store` equals opcode bit 0.
- R3: For opcode 0110 (load) or 0111 (store), `addr` is `base_val + sext(instr[5:0])` one cycle after `start`, with `mem_go`=1, `done`=1 and `mem_store` equal to opcode bit 0.
- R4: All address sums wrap modulo 2^16. Both a carry out of bit 15 and a borrow below zero are discarded.
- R5: For opcode 1010 or 1011, the cycle after `start` shows `ptr_rd`=1, `busy`=1, `done`=0, `mem_go`=0 and `addr = pc_inc + sext(instr[8:0])`. All of these hold steady until `ptr_valid` is seen.
- R6: In the cycle after `ptr_valid`=1 is sampled while `ptr_rd` is high, `addr` equals the sampled `ptr_data`, with `mem_go`=1 and `done`=1. `mem_store` is 1 for opcode 1011 and 0 for 1010, and `busy` is 0.
- R7: For opcode 1110, `reg_wr_en`=1 and `reg_wr_data = pc_inc + sext(instr[8:0])` one cycle after `start`, with `done`=1 and both `mem_go` and `ptr_rd` at 0.
- R8: For opcode 1100, `jmp_go`=1 and `addr` equals all 16 bits of `base_val` one cycle after `start`, with `done`=1.
- R9: A `start` sampled while `busy`=1 is dropped. It produces no strobe and no `done`, either in that sequence or afterwards.
- R10: Any other opcode gives `done`=1 one cycle after `start`, with `mem_go`, `ptr_rd`, `reg_wr_en` and `jmp_go` all 0.
- R11: At most one of `mem_go`, `ptr_rd`, `reg_wr_en` and `jmp_go` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction present on `instr`, `pc_inc` and `base_val` |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | PC already advanced past the instruction |
| base_val | input | 16 | Contents of the register named by `instr[8:6]` |
| ptr_valid | input | 1 | Pointer word on `ptr_data` is valid |
| ptr_data | input | 16 | Pointer word read from memory |
| addr | output | 16 | Memory address or jump target |
| ptr_rd | output | 1 | Request to read the pointer word at `addr` |
| mem_go | output | 1 | Final memory access at `addr` |
| mem_store | output | 1 | Direction of the `mem_go` access: 1 is a write |
| reg_wr_en | output | 1 | Write `reg_wr_data` to the destination register |
| reg_wr_data | output | 16 | Address value for the address-only form |
| jmp_go | output | 1 | Load `addr` into the PC |
| done | output | 1 | Instruction handling complete |
| busy | output | 1 | Indirect sequence waiting for its pointer |

## Verification
The pointer return that completes an indirect sequence can land in the same cycle as a new `start`. The bench first holds an address-only `start` high while the pointer is still outstanding. It then raises `start` and `ptr_valid` together. It judges the result at the ports: the cycle after must show only the indirect completion, with the pointer as `addr`, `mem_go` high and `reg_wr_en` low. The cycle after that must show no `done`, which proves the colliding instruction was dropped. It also checks that a store-type indirect keeps its direction through the pointer phase, and that the sums wrap at both ends of the address range.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned OFFL_W = 9;
  localparam int unsigned OFFS_W = 6;

  typedef enum logic [2:0] {
    MD_NONE, MD_PCREL, MD_BASE, MD_IND, MD_ADDR_ONLY, MD_JUMP
  } ea_mode_e;

  typedef enum logic {
    ST_IDLE, ST_PTR
  } ea_state_e;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ea_mode_e        mode,
  output logic            is_store
);
  always_comb begin
    is_store = 1'b0;
    unique case (opcode)
      4'b0010, 4'b0011: begin mode = MD_PCREL; is_store = opcode[0]; end
      4'b0110, 4'b0111: begin mode = MD_BASE;  is_store = opcode[0]; end
      4'b1010, 4'b1011: begin mode = MD_IND;   is_store = opcode[0]; end
      4'b1110:          mode = MD_ADDR_ONLY;
      4'b1100:          mode = MD_JUMP;
      default:          mode = MD_NONE;
    endcase
  end
endmodule

// File: rtl/ea_adder.sv
module ea_adder
  import ea_pkg::*;
#(
  parameter int unsigned W      = WORD_W,
  parameter int unsigned LONG_W = OFFL_W,
  parameter int unsigned SHRT_W = OFFS_W
) (
  input  ea_mode_e          mode,
  input  logic [W-1:0]      pc_inc,
  input  logic [W-1:0]      base_val,
  input  logic [LONG_W-1:0] off_long,
  output logic [W-1:0]      ea
);
  localparam int unsigned LPAD = W - LONG_W;
  localparam int unsigned SPAD = W - SHRT_W;

  logic [W-1:0] long_ext, shrt_ext, opnd_a, opnd_b;

  assign long_ext = {{LPAD{off_long[LONG_W-1]}}, off_long};
  assign shrt_ext = {{SPAD{off_long[SHRT_W-1]}}, off_long[SHRT_W-1:0]};

  always_comb begin
    unique case (mode)
      MD_BASE: begin opnd_a = base_val; opnd_b = shrt_ext; end
      MD_JUMP: begin opnd_a = base_val; opnd_b = '0;       end
      default: begin opnd_a = pc_inc;   opnd_b = long_ext; end
    endcase
  end

  // sum truncated to W bits: wraps modulo 2^W
  assign ea = opnd_a + opnd_b;
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  ea_mode_e     mode,
  input  logic         is_store,
  input  logic [W-1:0] ea,
  input  logic         ptr_valid,
  input  logic [W-1:0] ptr_data,
  output logic [W-1:0] addr,
  output logic         ptr_rd,
  output logic         mem_go,
  output logic         mem_store,
  output logic         reg_wr_en,
  output logic [W-1:0] reg_wr_data,
  output logic         jmp_go,
  output logic         done,
  output logic         busy
);
  ea_state_e    state_q, state_d;
  logic [W-1:0] addr_q, addr_d, wdat_q, wdat_d;
  logic         go_q, go_d, st_q, st_d, wr_q, wr_d, jmp_q, jmp_d, done_q, done_d;
  logic         pend_q, pend_d;
  logic         addr_en, wdat_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    pend_d  = pend_q;
    go_d    = 1'b0;
    st_d    = 1'b0;
    wr_d    = 1'b0;
    jmp_d   = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        done_d = 1'b1;
        unique case (mode)
          MD_PCREL, MD_BASE: begin addr_d = ea; go_d = 1'b1; st_d = is_store; end
          MD_IND: begin
            addr_d  = ea;
            pend_d  = is_store;
            done_d  = 1'b0;
            state_d = ST_PTR;
          end
          MD_ADDR_ONLY: begin wdat_d = ea; wr_d = 1'b1; end
          MD_JUMP:      begin addr_d = ea; jmp_d = 1'b1; end
          default: ;
        endcase
      end
      ST_PTR: if (ptr_valid) begin
        addr_d  = ptr_data;
        go_d    = 1'b1;
        st_d    = pend_q;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign addr_en = (addr_d != addr_q);
  assign wdat_en = wr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdat_q  <= '0;
      pend_q  <= 1'b0;
      go_q    <= 1'b0;
      st_q    <= 1'b0;
      wr_q    <= 1'b0;
      jmp_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q <= addr_d;
      if (wdat_en) wdat_q <= wdat_d;
      pend_q  <= pend_d;
      go_q    <= go_d;
      st_q    <= st_d;
      wr_q    <= wr_d;
      jmp_q   <= jmp_d;
      done_q  <= done_d;
    end
  end

  assign addr        = addr_q;
  assign ptr_rd      = (state_q == ST_PTR);
  assign busy        = (state_q == ST_PTR);
  assign mem_go      = go_q;
  assign mem_store   = st_q;
  assign reg_wr_en   = wr_q;
  assign reg_wr_data = wdat_q;
  assign jmp_go      = jmp_q;
  assign done        = done_q;

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd && !ptr_valid |=> ptr_rd && !done && $stable(addr));
  // R6
  ptr_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd && ptr_valid |=> mem_go && done && !busy && addr == $past(ptr_data));
  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !ptr_valid |=> busy && !done && !reg_wr_en && !jmp_go);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pc_inc,
  input  logic [WORD_W-1:0] base_val,
  input  logic              ptr_valid,
  input  logic [WORD_W-1:0] ptr_data,
  output logic [WORD_W-1:0] addr,
  output logic              ptr_rd,
  output logic              mem_go,
  output logic              mem_store,
  output logic              reg_wr_en,
  output logic [WORD_W-1:0] reg_wr_data,
  output logic              jmp_go,
  output logic              done,
  output logic              busy
);
  ea_mode_e          mode;
  logic              is_store;
  logic [WORD_W-1:0] ea;

  ea_decode u_dec (
    .opcode   (instr[WORD_W-1 -: OP_W]),
    .mode     (mode),
    .is_store (is_store)
  );

  ea_adder #(.W(WORD_W), .LONG_W(OFFL_W), .SHRT_W(OFFS_W)) u_add (
    .mode     (mode),
    .pc_inc   (pc_inc),
    .base_val (base_val),
    .off_long (instr[OFFL_W-1:0]),
    .ea       (ea)
  );

  ea_ctrl #(.W(WORD_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode        (mode),
    .is_store    (is_store),
    .ea          (ea),
    .ptr_valid   (ptr_valid),
    .ptr_data    (ptr_data),
    .addr        (addr),
    .ptr_rd      (ptr_rd),
    .mem_go      (mem_go),
    .mem_store   (mem_store),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .jmp_go      (jmp_go),
    .done        (done),
    .busy        (busy)
  );

  // R11
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_go, ptr_rd, reg_wr_en, jmp_go}));
  // R7
  addr_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> done && !mem_go && !ptr_rd);
  // R2
  go_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_go || jmp_go || reg_wr_en) |-> done);
endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n, start, ptr_valid;
  logic [15:0] instr, pc_inc, base_val, ptr_data;
  logic [15:0] addr, reg_wr_data;
  logic        ptr_rd, mem_go, mem_store, reg_wr_en, jmp_go, done, busy;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ea_gen u_dut (.*);

  function automatic logic [15:0] sx9(input logic [15:0] i);
    return {{7{i[8]}}, i[8:0]};
  endfunction
  function automatic logic [15:0] sx6(input logic [15:0] i);
    return {{10{i[5]}}, i[5:0]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic strobes(input string tag, input logic [4:0] exp);
    chk(tag, {11'd0, mem_go, ptr_rd, reg_wr_en, jmp_go, done}, {11'd0, exp});
  endtask

  task automatic issue(input logic [15:0] i, input logic [15:0] pc, input logic [15:0] b);
    @(negedge clk);
    start = 1'b1; instr = i; pc_inc = pc; base_val = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 0; ptr_valid = 0; instr = 0; pc_inc = 0; base_val = 0; ptr_data = 0;
    repeat (2) @(negedge clk);
    strobes("R1 in reset", 5'b00000);
    chk("R1 busy", {15'd0, busy}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    strobes("R1 after reset", 5'b00000);
  endtask

  task automatic t_pcrel();
    logic [15:0] i;
    i = 16'h2000 | 16'h01F4;
    issue(i, 16'h3001, 16'h0);
    chk("R2 load addr", addr, 16'h3001 + sx9(i));
    strobes("R2 load strobes", 5'b10001);
    chk("R2 load dir", {15'd0, mem_store}, 16'd0);
    i = 16'h3000 | 16'h0042;
    issue(i, 16'h30F0, 16'h0);
    chk("R2 store addr", addr, 16'h30F0 + sx9(i));
    chk("R2 store dir", {15'd0, mem_store}, 16'd1);
  endtask

  task automatic t_base();
    logic [15:0] i;
    i = 16'h6000 | 16'h0080 | 16'h0021;
    issue(i, 16'h1111, 16'h4000);
    chk("R3 load addr", addr, 16'h4000 + sx6(i));
    strobes("R3 strobes", 5'b10001);
    i = 16'h7000 | 16'h000E;
    issue(i, 16'h1111, 16'h30F4);
    chk("R3 store addr", addr, 16'h3102);
    chk("R3 store dir", {15'd0, mem_store}, 16'd1);
  endtask

  task automatic t_wrap();
    issue(16'h2001, 16'hFFFF, 16'h0);
    chk("R4 carry wrap", addr, 16'h0000);
    issue(16'h603D, 16'h0, 16'h0002);
    chk("R4 borrow wrap", addr, 16'hFFFF);
  endtask

  task automatic t_indirect(input logic store, input int wait_cyc);
    logic [15:0] i;
    i = (store ? 16'hB000 : 16'hA000) | 16'h01FB;
    issue(i, 16'h30FC, 16'h0);
    chk("R5 ptr addr", addr, 16'h30FC + sx9(i));
    strobes("R5 phase1", 5'b01000);
    chk("R5 busy", {15'd0, busy}, 16'd1);
    for (int k = 0; k < wait_cyc; k++) begin
      @(negedge clk);
      strobes("R5 hold", 5'b01000);
      chk("R5 hold addr", addr, 16'h30FC + sx9(i));
    end
    ptr_valid = 1'b1; ptr_data = store ? 16'h3102 : 16'hBEEF;
    @(negedge clk);
    ptr_valid = 1'b0;
    chk("R6 final addr", addr, store ? 16'h3102 : 16'hBEEF);
    strobes("R6 phase2", 5'b10001);
    chk("R6 dir", {15'd0, mem_store}, {15'd0, store});
    chk("R6 busy", {15'd0, busy}, 16'd0);
  endtask

  task automatic t_lea();
    issue(16'hE3FD, 16'h30F7, 16'h0);
    chk("R7 data", reg_wr_data, 16'h30F4);
    strobes("R7 strobes", 5'b00101);
  endtask

  task automatic t_jump();
    issue(16'hC1C0 | 16'h003F, 16'h1234, 16'h8765);
    chk("R8 target", addr, 16'h8765);
    strobes("R8 strobes", 5'b00011);
  endtask

  task automatic t_other();
    issue(16'h1234, 16'h0, 16'h0);
    strobes("R10 add op", 5'b00001);
    issue(16'hF025, 16'h0, 16'h0);
    strobes("R10 trap op", 5'b00001);
    issue(16'h0E05, 16'h0, 16'h0);
    strobes("R10 branch op", 5'b00001);
  endtask

  task automatic t_collide();
    issue(16'hA005, 16'h2000, 16'h0);
    strobes("R9 phase1", 5'b01000);
    @(negedge clk);
    start = 1'b1; instr = 16'hE010; pc_inc = 16'h0100;
    @(negedge clk);
    strobes("R9 start while waiting", 5'b01000);
    ptr_valid = 1'b1; ptr_data = 16'h5A5A;
    @(negedge clk);
    start = 1'b0; ptr_valid = 1'b0;
    chk("R9 collide addr", addr, 16'h5A5A);
    strobes("R9 collide strobes", 5'b10001);
    @(negedge clk);
    strobes("R9 dropped", 5'b00000);
    chk("R9 wr data untouched", reg_wr_data, 16'h30F4);
  endtask

  initial begin
    t_reset();
    t_pcrel();
    t_base();
    t_wrap();
    t_indirect(1'b0, 0);
    t_indirect(1'b1, 3);
    t_lea();
    t_jump();
    t_other();
    t_collide();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule